// File: doc/BRIEF.md
# Burst Line-Fill Memory Controller

This controller sits between a processor-side request port and a synchronous SRAM. It moves cache lines of four words, either as a fill (read) or as a write-back (write). The requester gives one starting word address and a command. The controller then produces every later word address from its own counter, so the requester does not have to drive an address after the first beat.

Two orders are available. Wrap-around order starts at the requested word and steps upward, modulo four, inside the aligned line. Linear order always walks the line from word 0 to word 3, whatever word was requested. A burst takes two clocks for its first beat and one clock for each of the other three, so it finishes in five clocks. A single-word mode is also provided, where one access costs three clocks. Read words are captured in a register clocked with the memory, and each captured word comes with a one-cycle valid strobe and its word offset. Write data is pulled from the requester in the same cycle that its address goes to the memory.

Top module: `burst_fill_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the block idle. After reset, busy, done, rd_valid, mem_en and mem_we are all low.
- R2: A burst request makes exactly four memory access cycles (mem_en high), in consecutive cycles. Done follows, and no further access is made.
- R3: Cycle 1 is the first cycle with busy high after the accepting edge. In burst mode, mem_en is high in cycles 1 to 4. The four read words appear with rd_valid high in cycles 3, 4, 5 and 6, so the first beat takes two clocks and each later beat takes one. Done is high in cycle 6.
- R4: In wrap-around burst mode (req_wrap=1), mem_addr[1:0] takes the values s, s+1, s+2, s+3 modulo 4, where s is req_addr[1:0]. mem_addr[AW-1:2] equals req_addr[AW-1:2] on every beat.
- R5: In linear burst mode (req_wrap=0), mem_addr[1:0] takes the values 0, 1, 2, 3 whatever req_addr[1:0] is. The upper address bits are the same as in R4.
- R6: In single-word mode (req_burst=0), there is exactly one access, in cycle 1, at req_addr unchanged. The read word appears with rd_valid in cycle 4, together with done, so the access takes three clocks.
- R7: Whenever rd_valid is high, rd_data holds the memory word at the line address combined with beat_off. beat_off gives the word offset (0 to 3) inside the line.
- R8: For a write (req_write=1), mem_we is high together with mem_en. mem_wdata equals wr_data in that same cycle, and wr_pull and wr_off mark the beat. rd_valid stays low for the whole write.
- R9: A request accepted with busy low makes busy high until the done cycle, inclusive. Requests made while busy is high, including in the done cycle, are ignored. A new request is accepted in the cycle after done.
- R10: Done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, shared with the SRAM |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while busy is low |
| req_write | input | 1 | 1 = write-back, 0 = fill |
| req_burst | input | 1 | 1 = four-word burst, 0 = single word |
| req_wrap | input | 1 | 1 = wrap-around order, 0 = linear order (burst only) |
| req_addr | input | AW | Starting word address |
| wr_data | input | DW | Write word supplied by the requester on each write beat |
| wr_pull | output | 1 | The current cycle takes wr_data |
| wr_off | output | 2 | Word offset of the word taken on wr_pull |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse that ends a transfer |
| rd_valid | output | 1 | rd_data holds a newly captured word |
| rd_data | output | DW | Captured read word |
| beat_off | output | 2 | Word offset of rd_data within the line |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM word address |
| mem_wdata | output | DW | SRAM write data |
| mem_rdata | input | DW | SRAM read data, valid the cycle after a read access |

## Verification
The in-module assertions check on every cycle that consecutive accesses keep the line address and step the word offset by one modulo four, and that accesses and write enables occur only inside a busy transfer. They also check that done lasts one cycle and is followed by an idle cycle, and that captured words appear only during reads. What only the bench scenarios can show is the absolute order: the wrap start word versus the forced zero start in linear mode, the exact 2-1-1-1 and three-clock cycle positions, and the data written and read back through the SRAM model. The same holds for requests held high through a whole transfer being ignored, and for back-to-back acceptance right after done.

// File: rtl/burst_fill_ctrl.sv
module burst_fill_ctrl #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_burst,
  input  logic          req_wrap,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_pull,
  output logic [1:0]    wr_off,
  output logic          busy,
  output logic          done,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    beat_off,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int LW = AW - 2;

  logic          burst_m, wr_m;
  logic [1:0]    start_off;
  logic [LW-1:0] line;
  logic [2:0]    cyc, cyc_m1, cyc_m2;
  logic          accept, capture;

  assign accept  = req_valid && !busy;
  assign cyc_m1  = cyc - 3'd1;
  assign cyc_m2  = cyc - 3'd2;
  assign done    = busy && (cyc == (burst_m ? 3'd6 : 3'd4));
  assign mem_en  = busy && (burst_m ? (cyc >= 3'd1 && cyc <= 3'd4) : (cyc == 3'd1));
  assign capture = busy && !wr_m && (burst_m ? (cyc >= 3'd2 && cyc <= 3'd5) : (cyc == 3'd3));
  assign mem_addr  = {line, 2'(start_off + cyc_m1[1:0])};
  assign mem_we    = mem_en && wr_m;
  assign mem_wdata = wr_data;
  assign wr_pull   = mem_we;
  assign wr_off    = mem_addr[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cyc       <= 3'd0;
      burst_m   <= 1'b0;
      wr_m      <= 1'b0;
      start_off <= 2'd0;
      line      <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      beat_off  <= 2'd0;
    end else begin
      rd_valid <= capture;
      if (capture) begin
        rd_data  <= mem_rdata;
        beat_off <= burst_m ? 2'(start_off + cyc_m2[1:0]) : start_off;
      end
      if (accept) begin
        busy      <= 1'b1;
        cyc       <= 3'd1;
        burst_m   <= req_burst;
        wr_m      <= req_write;
        line      <= req_addr[AW-1:2];
        start_off <= (req_burst && !req_wrap) ? 2'd0 : req_addr[1:0];
      end else if (busy) begin
        cyc <= cyc + 3'd1;
        if (done) busy <= 1'b0;
      end
    end
  end

  assert_idle_reset_R1: assert property (@(posedge clk) rst |=> !busy && !rd_valid);
  assert_en_in_busy_R2: assert property (@(posedge clk) disable iff (rst) mem_en |-> busy && !done);
  assert_line_fixed_R4: assert property (@(posedge clk) disable iff (rst)
    mem_en && $past(mem_en) |-> $stable(mem_addr[AW-1:2]));
  assert_offset_step_R5: assert property (@(posedge clk) disable iff (rst)
    mem_en && $past(mem_en) |-> mem_addr[1:0] == 2'($past(mem_addr[1:0]) + 2'd1));
  assert_valid_read_R7: assert property (@(posedge clk) disable iff (rst) rd_valid |-> busy && !mem_we);
  assert_we_with_en_R8: assert property (@(posedge clk) disable iff (rst) mem_we |-> mem_en);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst) done |=> !busy);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst) done |=> !done);
endmodule

// File: tb/test_burst_fill_ctrl.sv
`timescale 1ns/100ps
module test_burst_fill_ctrl;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0, req_wrap = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_pull, busy, done, rd_valid, mem_en, mem_we;
  logic [1:0] wr_off, beat_off;
  logic [DW-1:0] rd_data, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] sram [int];
  logic [DW-1:0] ref_mem [int];

  always #2.5 clk = ~clk;

  burst_fill_ctrl #(.AW(AW), .DW(DW)) i_burst_fill_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_burst(req_burst), .req_wrap(req_wrap), .req_addr(req_addr),
    .wr_data(wr_data), .wr_pull(wr_pull), .wr_off(wr_off), .busy(busy),
    .done(done), .rd_valid(rd_valid), .rd_data(rd_data), .beat_off(beat_off),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  function automatic logic [DW-1:0] init_word(int a);
    return (32'(a) * 32'h0100_0193) ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [DW-1:0] ref_word(int a);
    return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
  endfunction

  always @(posedge clk) begin
    if (mem_en && mem_we) sram[int'(mem_addr)] = mem_wdata;
    else if (mem_en) mem_rdata <= sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : init_word(int'(mem_addr));
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_chk(input string tag);
    chk(busy == 0, {tag, " busy"}, 64'(busy), 0);
    chk(mem_en == 0, {tag, " mem_en"}, 64'(mem_en), 0);
    chk(done == 0, {tag, " done"}, 64'(done), 0);
    chk(rd_valid == 0, {tag, " rd_valid"}, 64'(rd_valid), 0);
  endtask

  // one transfer, checked in every cycle from request to done
  task automatic xfer(input bit wr, input bit bst, input bit wrp, input logic [AW-1:0] a, input bit hold);
    int n = bst ? 6 : 4;
    int line = int'(a) & ~3;
    int offs[$];
    int rd_q[$];
    if (bst) for (int k = 0; k < 4; k++) offs.push_back(wrp ? ((int'(a[1:0]) + k) % 4) : k);
    else offs.push_back(int'(a[1:0]));
    @(negedge clk);
    req_valid = 1; req_write = wr; req_burst = bst; req_wrap = wrp; req_addr = a;
    #0.5;
    chk(busy == 0, "R9 accept when idle", 64'(busy), 0);
    for (int c = 1; c <= n; c++) begin
      int nacc = bst ? 4 : 1;
      bit en_exp = (c <= nacc);
      bit rv_exp = !wr && (bst ? (c >= 3) : (c == 4));
      @(negedge clk);
      if (hold) begin
        req_valid = 1; req_write = ~wr; req_burst = 1; req_wrap = 1; req_addr = a ^ 16'h0155;
      end else req_valid = 0;
      if (en_exp && wr) wr_data = 32'hC0DE_0000 | 32'(line << 4) | 32'(c);
      #0.5;
      chk(busy == 1, "R9 busy through transfer", 64'(busy), 1);
      chk(mem_en == en_exp, bst ? "R3 access cycle" : "R6 single access cycle", 64'(mem_en), 64'(en_exp));
      chk(done == (c == n), "R10 done position", 64'(done), 64'(c == n));
      chk(rd_valid == rv_exp, bst ? "R3 beat valid timing" : "R6 single valid timing", 64'(rd_valid), 64'(rv_exp));
      if (en_exp) begin
        int ea = line + offs[c-1];
        chk(int'(mem_addr) == ea, wrp ? "R4 wrap address" : (bst ? "R5 linear address" : "R6 single address"),
            64'(mem_addr), 64'(ea));
        chk(mem_we == wr, "R8 write enable", 64'(mem_we), 64'(wr));
        if (wr) begin
          chk(mem_wdata == wr_data, "R8 write data same cycle", 64'(mem_wdata), 64'(wr_data));
          chk(wr_pull == 1 && int'(wr_off) == offs[c-1], "R8 pull offset", 64'(wr_off), 64'(offs[c-1]));
          ref_mem[ea] = wr_data;
        end else rd_q.push_back(ea);
      end
      if (rv_exp) begin
        int ea = rd_q.pop_front();
        chk(rd_data == ref_word(ea), "R7 read data", 64'(rd_data), 64'(ref_word(ea)));
        chk(int'(beat_off) == (ea & 3), "R7 beat offset", 64'(beat_off), 64'(ea & 3));
      end
    end
    chk(rd_q.size() == 0, "R2 all words returned", 64'(rd_q.size()), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #0.5;
    idle_chk("R1 after reset");
    chk(mem_we == 0, "R1 mem_we", 64'(mem_we), 0);

    xfer(0, 1, 1, 16'h0122, 0);   // wrap from word 2
    xfer(0, 1, 0, 16'h0133, 0);   // linear, requested word 3
    xfer(1, 1, 1, 16'h0241, 0);   // write-back wrap from word 1
    xfer(0, 1, 1, 16'h0243, 0);   // read back the written line
    xfer(0, 1, 0, 16'h0240, 0);
    xfer(0, 0, 0, 16'h0312, 0);   // single read
    xfer(1, 0, 1, 16'h0313, 0);   // single write
    xfer(0, 0, 0, 16'h0313, 0);
    xfer(0, 1, 1, 16'h0400, 1);   // requests held high while busy
    xfer(1, 1, 0, 16'h0502, 1);
    xfer(0, 1, 0, 16'h0501, 0);
    @(negedge clk); req_valid = 0; #0.5;
    idle_chk("R9 nothing accepted after hold");

    // reset in the middle of a burst
    @(negedge clk);
    req_valid = 1; req_write = 0; req_burst = 1; req_wrap = 1; req_addr = 16'h0600;
    @(negedge clk); req_valid = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; #0.5;
    idle_chk("R1 reset mid burst");
    @(negedge clk); #0.5;
    idle_chk("R1 stays idle");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule